// File: doc/BRIEF.md
# Multislope Run-up Sequencer

This block sequences the run-up phase of a multislope integrating converter. After a start request it runs one integration frame, split into a fixed number of equal slots. At the first cycle of every slot it reads a synchronized comparator level and selects the polarity of the reference for the whole slot, so that the integrator is driven back toward zero. The last few cycles of each slot are a dead window with no reference applied, so every slot carries the same switching error.

The block counts the slots that applied the positive reference. When the frame closes, this coarse count is placed in a held result register and a one-cycle done strobe fires. A valid/ready handoff then passes control to the rundown stage. `rd_valid_o` rises with the done strobe and stays high, with the references off, until `rd_ready_i` is sampled high. `count_o` is the payload of that handoff. It does not change while `rd_valid_o` is high, so the rundown stage may stall as long as it needs. There is no integrator reset. Whatever residual remains after rundown is the starting point of the next frame, which begins only on a new start request.

Top module: `msl_runup_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `busy_o`, `ref_pos_o`, `ref_neg_o`, `frame_done_o` and `rd_valid_o` are low and `count_o` is zero.
- R2: A start sampled high while idle opens a frame of SLOTS*SLOT_CYCLES cycles. `frame_done_o` is high for exactly one cycle, namely the cycle that follows the edge that closes the last slot.
- R3: Each slot's polarity is the `cmp_i` level seen through SYNC_STAGES flops at the slot's first edge. `cmp_i`=1 selects the positive reference (`ref_pos_o`) and 0 selects the negative reference (`ref_neg_o`). The polarity holds for the whole slot, and a level applied SYNC_STAGES+1 cycles before the slot edge is the one used.
- R4: In the last DEAD_CYCLES cycles of every slot both reference selects are low. In the other cycles of a frame exactly one of them is high, and the two are never high together.
- R5: At frame end, `count_o` equals the number of slots in that frame that used the positive reference, in the range 0 to SLOTS.
- R6: `count_o` changes only in the cycle where `frame_done_o` is high, and it holds its value through the whole next frame.
- R7: `rd_valid_o` rises together with `frame_done_o` and stays high, with both references low, until it is accepted by `rd_ready_i` high at a clock edge.
- R8: A start that arrives while a frame or its handoff is in progress is ignored and is not remembered. After the handshake the block is idle until a new start arrives.
- R9: `busy_o` is high from the edge that accepts a start through the edge that completes the handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to open a frame, honoured only when idle |
| cmp_i | input | 1 | Asynchronous comparator level; 1 asks for the positive reference |
| rd_ready_i | input | 1 | Rundown stage accepts the handoff |
| ref_pos_o | output | 1 | Apply the positive reference |
| ref_neg_o | output | 1 | Apply the negative reference |
| busy_o | output | 1 | Frame or handoff in progress |
| frame_done_o | output | 1 | One-cycle strobe at frame end |
| rd_valid_o | output | 1 | Handoff to rundown pending |
| count_o | output | $clog2(SLOTS+1) | Coarse count of the last completed frame |

## Verification
The situation hardest to reach from the ports is a comparator change placed right at the synchronizer's limit, together with starts that arrive mid-frame and during a stalled handoff. The bench counts edges from the accepted start. It changes `cmp_i` exactly DEAD_CYCLES edges before each slot boundary, which is the latest point that still reaches the decision. At that same point it checks the dead window and injects stray starts. It then holds `rd_ready_i` low for several cycles before releasing it. Patterns of all-positive, all-negative, alternating and a single step cover both ends of the count range.

// File: rtl/msl_runup_pkg.sv
`timescale 1ns/1ps
package msl_runup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HAND = 2'd2
  } runup_state_e;
endpackage

// File: rtl/msl_cmp_sync.sv
`timescale 1ns/1ps
module msl_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b0;
        else        sr[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b0;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/msl_slot_timer.sv
`timescale 1ns/1ps
module msl_slot_timer #(
  parameter int SLOT_CYCLES = 20,
  parameter int DEAD_CYCLES = 4,
  parameter int SLOTS       = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic run_i,
  output logic slot_end_o,
  output logic frame_end_o,
  output logic drive_o
);
  localparam int CYC_W  = $clog2(SLOT_CYCLES);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYCLES - 1);
  localparam logic [CYC_W-1:0]  DRIVE_END = CYC_W'(SLOT_CYCLES - DEAD_CYCLES);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [CYC_W-1:0]  cyc_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n || launch_i) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (run_i) begin
      if (cyc_q == CYC_LAST) begin
        cyc_q  <= '0;
        slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign slot_end_o  = run_i && (cyc_q == CYC_LAST);
  assign frame_end_o = slot_end_o && (slot_q == SLOT_LAST);
  assign drive_o     = run_i && (cyc_q < DRIVE_END);
endmodule

// File: rtl/msl_slot_tally.sv
`timescale 1ns/1ps
module msl_slot_tally #(
  parameter int SLOTS = 1000,
  localparam int COUNT_W = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               first_i,
  input  logic               next_i,
  input  logic               bit_i,
  input  logic               commit_i,
  output logic [COUNT_W-1:0] count_o
);
  logic [COUNT_W-1:0] tally_q;
  logic [COUNT_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        tally_q <= '0;
    else if (first_i)  tally_q <= COUNT_W'(bit_i);
    else if (next_i)   tally_q <= tally_q + COUNT_W'(bit_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        held_q <= '0;
    else if (commit_i) held_q <= tally_q;
  end

  assign count_o = held_q;
endmodule

// File: rtl/msl_runup_ctrl.sv
`timescale 1ns/1ps
module msl_runup_ctrl #(
  parameter int SLOT_CYCLES = 20,
  parameter int DEAD_CYCLES = 4,
  parameter int SLOTS       = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int COUNT_W    = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               cmp_i,
  input  logic               rd_ready_i,
  output logic               ref_pos_o,
  output logic               ref_neg_o,
  output logic               busy_o,
  output logic               frame_done_o,
  output logic               rd_valid_o,
  output logic [COUNT_W-1:0] count_o
);
  import msl_runup_pkg::*;

  runup_state_e state_q;
  logic pol_q, done_q, cmp_s;
  logic launch, run, slot_end, frame_end, drive, next_dec;

  assign launch   = (state_q == ST_IDLE) && start_i;
  assign run      = (state_q == ST_RUN);
  assign next_dec = slot_end && !frame_end;

  msl_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
  );

  msl_slot_timer #(
    .SLOT_CYCLES(SLOT_CYCLES), .DEAD_CYCLES(DEAD_CYCLES), .SLOTS(SLOTS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .run_i(run),
    .slot_end_o(slot_end), .frame_end_o(frame_end), .drive_o(drive)
  );

  msl_slot_tally #(.SLOTS(SLOTS)) u_tally (
    .clk(clk), .rst_n(rst_n), .first_i(launch), .next_i(next_dec),
    .bit_i(cmp_s), .commit_i(frame_end), .count_o(count_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pol_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= frame_end;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          pol_q   <= cmp_s;
        end
        ST_RUN: if (frame_end) begin
          state_q <= ST_HAND;
        end else if (slot_end) begin
          pol_q <= cmp_s;
        end
        ST_HAND: if (rd_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ref_pos_o    = drive && pol_q;
  assign ref_neg_o    = drive && !pol_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign rd_valid_o   = (state_q == ST_HAND);
  assign frame_done_o = done_q;
endmodule

// File: rtl/msl_runup_chk.sv
`timescale 1ns/1ps
module msl_runup_chk #(
  parameter int SLOTS   = 1000,
  parameter int COUNT_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_ready_i,
  input logic               ref_pos_o,
  input logic               ref_neg_o,
  input logic               busy_o,
  input logic               frame_done_o,
  input logic               rd_valid_o,
  input logic [COUNT_W-1:0] count_o
);
  p_ref_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_pos_o && ref_neg_o));

  p_pos_then_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pos_o |=> !ref_neg_o);

  p_neg_then_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_neg_o |=> !ref_pos_o);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_o |-> $stable(count_o));

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= COUNT_W'(SLOTS));

  p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> rd_valid_o);

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o);

  p_refs_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o || !busy_o) |-> !(ref_pos_o || ref_neg_o));

  p_busy_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> busy_o);
endmodule

bind msl_runup_ctrl msl_runup_chk #(.SLOTS(SLOTS), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ready_i(rd_ready_i), .ref_pos_o(ref_pos_o),
  .ref_neg_o(ref_neg_o), .busy_o(busy_o), .frame_done_o(frame_done_o),
  .rd_valid_o(rd_valid_o), .count_o(count_o)
);

// File: tb/msl_runup_ctrl_test.sv
`timescale 1ns/1ps
module msl_runup_ctrl_test;
  localparam int SC = 8;
  localparam int DC = 3;
  localparam int NS = 50;
  localparam int CW = $clog2(NS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, cmp_i = 1'b0, rd_ready_i = 1'b0;
  logic ref_pos_o, ref_neg_o, busy_o, frame_done_o, rd_valid_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int last_exp = 0;

  always #4 clk = ~clk;

  msl_runup_ctrl #(.SLOT_CYCLES(SC), .DEAD_CYCLES(DC), .SLOTS(NS), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .rd_ready_i(rd_ready_i), .ref_pos_o(ref_pos_o), .ref_neg_o(ref_neg_o),
    .busy_o(busy_o), .frame_done_o(frame_done_o), .rd_valid_o(rd_valid_o),
    .count_o(count_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int mode, input int k);
    case (mode)
      0: return bit'(k % 2);
      1: return 1'b1;
      2: return 1'b0;
      default: return k < 37;
    endcase
  endfunction

  // monitor: scoreboard pop on each done strobe (R5)
  always @(negedge clk) begin
    if (rst_n && frame_done_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected frame", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(count_o == CW'(e), "R5 coarse count", int'(count_o), e);
      end
    end
  end

  task automatic run_frame(input int mode, input bit spam, input int stall);
    int e = 0;
    for (int k = 0; k < NS; k++) e += int'(pat(mode, k));
    exp_q.push_back(e);
    @(negedge clk) cmp_i = pat(mode, 0);
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", int'(busy_o), 1);
    chk(ref_pos_o == pat(mode, 0) && ref_neg_o == !pat(mode, 0), "R3 slot0 polarity",
        int'(ref_pos_o), int'(pat(mode, 0)));
    for (int k = 1; k <= NS; k++) begin
      repeat (SC - DC) @(negedge clk);
      chk(!ref_pos_o && !ref_neg_o, "R4 dead window", int'({ref_pos_o, ref_neg_o}), 0);
      if (k < NS) cmp_i = pat(mode, k);
      if (spam) start_i = 1'b1;
      repeat (DC) @(negedge clk);
      start_i = 1'b0;
      if (k < NS) begin
        chk(ref_pos_o == pat(mode, k) && ref_neg_o == !pat(mode, k), "R3 slot polarity",
            int'(ref_pos_o), int'(pat(mode, k)));
        if (k == NS / 2)
          chk(count_o == CW'(last_exp), "R6 count held mid-frame", int'(count_o), last_exp);
        if (k < NS - 1)
          chk(frame_done_o == 1'b0, "R2 no early done", int'(frame_done_o), 0);
      end
    end
    chk(frame_done_o == 1'b1, "R2 done at frame end", int'(frame_done_o), 1);
    chk(rd_valid_o == 1'b1, "R7 valid with done", int'(rd_valid_o), 1);
    last_exp = e;
    for (int s = 0; s < stall; s++) begin
      if (spam) start_i = 1'b1;
      @(negedge clk);
      chk(rd_valid_o && !ref_pos_o && !ref_neg_o, "R7 held under stall", int'(rd_valid_o), 1);
      chk(frame_done_o == 1'b0, "R2 done single cycle", int'(frame_done_o), 0);
    end
    rd_ready_i = 1'b1;
    if (spam) start_i = 1'b1;
    @(negedge clk);
    rd_ready_i = 1'b0;
    start_i = 1'b0;
    chk(!rd_valid_o && !busy_o, "R8 idle after handshake", int'(busy_o), 0);
    repeat (12) @(negedge clk);
    chk(!busy_o && !ref_pos_o && !ref_neg_o, "R8 stray start not remembered", int'(busy_o), 0);
    chk(count_o == CW'(e), "R6 count held after frame", int'(count_o), e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy_o && !ref_pos_o && !ref_neg_o && !frame_done_o && !rd_valid_o && count_o == '0,
        "R1 state in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !rd_valid_o && count_o == '0, "R1 state after reset", int'(count_o), 0);
    run_frame(0, 1'b0, 0);
    run_frame(1, 1'b1, 5);
    run_frame(2, 1'b0, 2);
    run_frame(3, 1'b1, 7);
    chk(exp_q.size() == 0, "R5 every frame reported", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule